// File: doc/BRIEF.md
# Packed Lane Narrow, Interleave and Shift Unit

This unit takes two 64-bit operands holding packed lanes and produces one 64-bit result a cycle later. It narrows lanes to half their width with signed or unsigned saturation. It interleaves the low or high halves of the two operands into lanes of twice the width. It shifts each lane, or the whole 64-bit word, left or right, either logically or arithmetically. An integer datapath issues one operation per cycle with `in_valid` and collects the result on `out_valid`.

The shift count comes from one of two places. It can be an immediate applied to every lane. It can also be taken from the second operand, where each lane reads its own count from the same-width field of `opb`, so neighbouring lanes can shift by different amounts. Unpacking adds no sign or zero extension of its own. Interleaving with an all-zero operand gives zero extension.

A two-state controller tracks the output register. `ST_IDLE` means no result is being presented, and `ST_LOADED` means a result is present. `ST_IDLE -> ST_LOADED` and `ST_LOADED -> ST_LOADED` are taken when `in_valid` is high. `ST_LOADED -> ST_IDLE` and `ST_IDLE -> ST_IDLE` are taken when it is low.

Top module: `pk_shift_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `out_data` is 0. In each later cycle `out_valid` equals the `in_valid` of the previous cycle, and the result of an operation accepted at one clock edge appears at the next edge.
- R2: Opcode 0x00 narrows signed 32-bit lanes to 16 bits, clamping to [-32768, 32767]. The dwords of `opa` fill words 0-1 and those of `opb` fill words 2-3, with lower lanes in lower positions.
- R3: Opcode 0x01 narrows signed 16-bit lanes to 8 bits, clamping to [-128, 127], so that 300 gives 127 and -144 gives -128. The words of `opa` fill bytes 0-3 and those of `opb` fill bytes 4-7.
- R4: Opcode 0x02 reads the 16-bit source lanes as signed and narrows them to unsigned bytes. Negative values give 0 and values above 255 give 255. The byte placement is the same as in R3.
- R5: Opcodes 0x04, 0x05 and 0x06 interleave the low halves of the operands at byte, word and dword size. Element i of `opa` goes to result element 2i and element i of `opb` goes to element 2i+1.
- R6: Opcodes 0x08, 0x09 and 0x0A do the same as R5 using the high halves, so that upper element i goes to result positions 2i and 2i+1.
- R7: Logical shifts are 0x10, 0x11 and 0x12 for left shifts by word, dword and qword, and 0x14, 0x15 and 0x16 for right shifts by the same sizes. A lane whose count is at least its width becomes 0.
- R8: Arithmetic right shifts are 0x18 by word and 0x19 by dword. A lane whose count is at least its width fills with its sign bit.
- R9: With `imm_sel`=1 every lane uses the zero-extended `imm_cnt`. With `imm_sel`=0 each lane uses the unsigned value of the `opb` field at the same position and width as that lane.
- R10: Any opcode not listed in R2-R8 produces a result of 0.
- R11: While `in_valid` is 0, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation issue strobe |
| op | input | 5 | Operation code |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand, also the per-lane shift counts |
| imm_sel | input | 1 | 1 selects the immediate shift count |
| imm_cnt | input | 8 | Immediate shift count |
| out_valid | output | 1 | Result valid, one cycle after issue |
| out_data | output | 64 | Registered result |

## Verification
Two functions can land in the same cycle inside a single operation. One lane can saturate or be flushed by an oversize count while its neighbour narrows or shifts normally. The bench provokes this with directed operands whose lanes straddle the clamp bounds, and with `opb` count vectors that hold a different count in every lane, some below and some above the lane width. The constrained-random mix then issues back-to-back operations, so a new result replaces the previous one at each edge. Each lane of every result is compared with a reference function that computes that lane on its own.

// File: rtl/pk_shift_pkg.sv
package pk_shift_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_PSS_DW = 5'h00,
        OP_PSS_WB = 5'h01,
        OP_PUS_WB = 5'h02,
        OP_UNLO_B = 5'h04,
        OP_UNLO_W = 5'h05,
        OP_UNLO_D = 5'h06,
        OP_UNHI_B = 5'h08,
        OP_UNHI_W = 5'h09,
        OP_UNHI_D = 5'h0A,
        OP_SLL_W  = 5'h10,
        OP_SLL_D  = 5'h11,
        OP_SLL_Q  = 5'h12,
        OP_SRL_W  = 5'h14,
        OP_SRL_D  = 5'h15,
        OP_SRL_Q  = 5'h16,
        OP_SRA_W  = 5'h18,
        OP_SRA_D  = 5'h19
    } op_e;

    typedef enum logic [1:0] {
        SH_LEFT = 2'd0,
        SH_RLOG = 2'd1,
        SH_RARI = 2'd2
    } shkind_e;

    typedef enum logic [1:0] {
        NW_S_DW = 2'd0,
        NW_S_WB = 2'd1,
        NW_U_WB = 2'd2
    } narrow_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } st_e;

endpackage

// File: rtl/pk_sat_pack.sv
module pk_sat_pack
    import pk_shift_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  narrow_e           mode,
    output logic [DATA_W-1:0] res
);
    localparam int N_DW = DATA_W / 32;
    localparam int N_WD = DATA_W / 16;

    function automatic logic [15:0] clamp_s16(input logic signed [31:0] v);
        if (v > 32'sd32767)       return 16'h7FFF;
        else if (v < -32'sd32768) return 16'h8000;
        else                      return v[15:0];
    endfunction

    function automatic logic [7:0] clamp_s8(input logic signed [15:0] v);
        if (v > 16'sd127)       return 8'h7F;
        else if (v < -16'sd128) return 8'h80;
        else                    return v[7:0];
    endfunction

    function automatic logic [7:0] clamp_u8(input logic signed [15:0] v);
        if (v < 16'sd0)        return 8'h00;
        else if (v > 16'sd255) return 8'hFF;
        else                   return v[7:0];
    endfunction

    logic [DATA_W-1:0] r_dw, r_swb, r_uwb;

    for (genvar i = 0; i < N_DW; i++) begin : g_dw
        assign r_dw[16*i +: 16]        = clamp_s16(opa[32*i +: 32]);
        assign r_dw[16*(i+N_DW) +: 16] = clamp_s16(opb[32*i +: 32]);
    end

    for (genvar i = 0; i < N_WD; i++) begin : g_wb
        assign r_swb[8*i +: 8]        = clamp_s8(opa[16*i +: 16]);
        assign r_swb[8*(i+N_WD) +: 8] = clamp_s8(opb[16*i +: 16]);
        assign r_uwb[8*i +: 8]        = clamp_u8(opa[16*i +: 16]);
        assign r_uwb[8*(i+N_WD) +: 8] = clamp_u8(opb[16*i +: 16]);
    end

    always_comb begin
        unique case (mode)
            NW_S_DW: res = r_dw;
            NW_S_WB: res = r_swb;
            NW_U_WB: res = r_uwb;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/pk_unpack.sv
module pk_unpack #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              upper,
    input  logic [1:0]        gran,
    output logic [DATA_W-1:0] res
);
    localparam int N_GRAN = 3;

    logic [N_GRAN-1:0][DATA_W-1:0] r_lo;
    logic [N_GRAN-1:0][DATA_W-1:0] r_hi;

    for (genvar g = 0; g < N_GRAN; g++) begin : g_gran
        localparam int EW = 8 << g;
        localparam int NE = DATA_W / (2 * EW);
        for (genvar i = 0; i < NE; i++) begin : g_el
            assign r_lo[g][(2*i)*EW +: EW]   = opa[i*EW +: EW];
            assign r_lo[g][(2*i+1)*EW +: EW] = opb[i*EW +: EW];
            assign r_hi[g][(2*i)*EW +: EW]   = opa[(i+NE)*EW +: EW];
            assign r_hi[g][(2*i+1)*EW +: EW] = opb[(i+NE)*EW +: EW];
        end
    end

    always_comb begin
        res = '0;
        if (gran < 2'(N_GRAN)) begin
            res = upper ? r_hi[gran] : r_lo[gran];
        end
    end
endmodule

// File: rtl/pk_lane_shift.sv
module pk_lane_shift
    import pk_shift_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] din,
    input  logic [LANE_W-1:0] cnt,
    input  shkind_e           kind,
    output logic [LANE_W-1:0] dout
);
    localparam int SH_W = $clog2(LANE_W);

    logic            oversize;
    logic [SH_W-1:0] amt;

    assign oversize = |(cnt >> SH_W);
    assign amt      = cnt[SH_W-1:0];

    always_comb begin
        unique case (kind)
            SH_LEFT: dout = oversize ? '0 : (din << amt);
            SH_RLOG: dout = oversize ? '0 : (din >> amt);
            SH_RARI: dout = oversize ? {LANE_W{din[LANE_W-1]}}
                                     : LANE_W'($signed(din) >>> amt);
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/pk_shift_unit.sv
module pk_shift_unit
    import pk_shift_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              imm_sel,
    input  logic [CNT_W-1:0]  imm_cnt,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int N_SHG = 3;

    // ---------------- decode ----------------
    narrow_e  nw_mode;
    logic     un_upper;
    logic [1:0] un_gran;
    shkind_e  sh_kind;
    logic [1:0] sh_gran;

    always_comb begin
        nw_mode  = NW_S_DW;
        un_upper = op[3];
        un_gran  = op[1:0];
        sh_kind  = SH_LEFT;
        sh_gran  = op[1:0];
        unique case (op[4:2])
            3'b000: nw_mode = narrow_e'(op[1:0]);
            3'b100: sh_kind = SH_LEFT;
            3'b101: sh_kind = SH_RLOG;
            3'b110: sh_kind = SH_RARI;
            default: sh_kind = SH_LEFT;
        endcase
    end

    // ---------------- datapaths ----------------
    logic [DATA_W-1:0] nw_res, un_res;

    pk_sat_pack #(.DATA_W(DATA_W)) u_pack (
        .opa (opa),
        .opb (opb),
        .mode(nw_mode),
        .res (nw_res)
    );

    pk_unpack #(.DATA_W(DATA_W)) u_unpack (
        .opa  (opa),
        .opb  (opb),
        .upper(un_upper),
        .gran (un_gran),
        .res  (un_res)
    );

    logic [N_SHG-1:0][DATA_W-1:0] sh_res;

    for (genvar g = 0; g < N_SHG; g++) begin : g_shg
        localparam int LW = 16 << g;
        localparam int NL = DATA_W / LW;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            logic [LW-1:0] lane_cnt;
            assign lane_cnt = imm_sel ? LW'(imm_cnt) : opb[i*LW +: LW];
            pk_lane_shift #(.LANE_W(LW)) u_lane (
                .din (opa[i*LW +: LW]),
                .cnt (lane_cnt),
                .kind(sh_kind),
                .dout(sh_res[g][i*LW +: LW])
            );
        end
    end

    // ---------------- result select ----------------
    logic [DATA_W-1:0] nxt_data;

    always_comb begin
        unique case (op)
            OP_PSS_DW, OP_PSS_WB, OP_PUS_WB:
                nxt_data = nw_res;
            OP_UNLO_B, OP_UNLO_W, OP_UNLO_D,
            OP_UNHI_B, OP_UNHI_W, OP_UNHI_D:
                nxt_data = un_res;
            OP_SLL_W, OP_SLL_D, OP_SLL_Q,
            OP_SRL_W, OP_SRL_D, OP_SRL_Q,
            OP_SRA_W, OP_SRA_D:
                nxt_data = sh_res[sh_gran];
            default:
                nxt_data = '0;
        endcase
    end

    // ---------------- controller ----------------
    st_e state, state_nxt;

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nxt = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_nxt = in_valid ? ST_LOADED : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        out_data <= '0;
        else if (in_valid) out_data <= nxt_data;
    end

    assign out_valid = (state == ST_LOADED);

endmodule

// File: rtl/pk_shift_unit_chk.sv
module pk_shift_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [4:0]  op,
    input logic [63:0] opa,
    input logic        imm_sel,
    input logic [7:0]  imm_cnt,
    input logic        out_valid,
    input logic [63:0] out_data
);
    logic known_op;
    always_comb begin
        unique case (op)
            5'h00, 5'h01, 5'h02, 5'h04, 5'h05, 5'h06, 5'h08, 5'h09, 5'h0A,
            5'h10, 5'h11, 5'h12, 5'h14, 5'h15, 5'h16, 5'h18, 5'h19:
                known_op = 1'b1;
            default:
                known_op = 1'b0;
        endcase
    end

    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !known_op) |=> (out_data == 64'd0));
    p_unlo_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'h04) |=> (out_data[7:0] == $past(opa[7:0])));
    p_sll_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'h12 && imm_sel && imm_cnt >= 8'd64) |=> (out_data == 64'd0));
    p_sra_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'h18 && imm_sel && imm_cnt >= 8'd16)
        |=> (out_data[15:0] == {16{$past(opa[15])}}));
endmodule

bind pk_shift_unit pk_shift_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op       (op),
    .opa      (opa),
    .imm_sel  (imm_sel),
    .imm_cnt  (imm_cnt),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/pk_shift_unit_bench.sv
module pk_shift_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        imm_sel = 1'b0;
    logic [7:0]  imm_cnt = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pk_shift_unit u_pk_shift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .imm_sel(imm_sel), .imm_cnt(imm_cnt),
        .out_valid(out_valid), .out_data(out_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic longint sx(input longint unsigned v, input int w);
        if (w == 64) return longint'(v);
        return (longint'(v << (64 - w))) >>> (64 - w);
    endfunction

    function automatic longint unsigned clampv(input longint v, input longint lo, input longint hi);
        if (v < lo) return longint'(lo);
        if (v > hi) return longint'(hi);
        return longint'(v);
    endfunction

    function automatic logic [63:0] model(input logic [4:0] o, input logic [63:0] a,
                                          input logic [63:0] b, input bit isel,
                                          input logic [7:0] imm);
        logic [63:0] r = '0;
        int lw, nl, kind;
        longint unsigned mask, lane, cnt, v;
        case (o)
            5'h00: for (int i = 0; i < 2; i++) begin
                r[16*i +: 16]     = 16'(clampv(sx(a[32*i +: 32], 32), -32768, 32767));
                r[16*(i+2) +: 16] = 16'(clampv(sx(b[32*i +: 32], 32), -32768, 32767));
            end
            5'h01: for (int i = 0; i < 4; i++) begin
                r[8*i +: 8]     = 8'(clampv(sx(a[16*i +: 16], 16), -128, 127));
                r[8*(i+4) +: 8] = 8'(clampv(sx(b[16*i +: 16], 16), -128, 127));
            end
            5'h02: for (int i = 0; i < 4; i++) begin
                r[8*i +: 8]     = 8'(clampv(sx(a[16*i +: 16], 16), 0, 255));
                r[8*(i+4) +: 8] = 8'(clampv(sx(b[16*i +: 16], 16), 0, 255));
            end
            5'h04, 5'h05, 5'h06, 5'h08, 5'h09, 5'h0A: begin
                lw = 8 << o[1:0];
                nl = 64 / (2 * lw);
                for (int i = 0; i < nl; i++) begin
                    int src = o[3] ? i + nl : i;
                    for (int k = 0; k < lw; k++) begin
                        r[2*i*lw + k]     = a[src*lw + k];
                        r[(2*i+1)*lw + k] = b[src*lw + k];
                    end
                end
            end
            5'h10, 5'h11, 5'h12, 5'h14, 5'h15, 5'h16, 5'h18, 5'h19: begin
                lw = 16 << o[1:0];
                nl = 64 / lw;
                kind = o[3] ? 2 : (o[2] ? 1 : 0);
                mask = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 1);
                for (int i = 0; i < nl; i++) begin
                    lane = (a >> (i*lw)) & mask;
                    cnt  = isel ? longint'(imm) : ((b >> (i*lw)) & mask);
                    if (kind == 0)      v = (cnt >= lw) ? 0 : ((lane << cnt) & mask);
                    else if (kind == 1) v = (cnt >= lw) ? 0 : (lane >> cnt);
                    else                v = longint'(sx(lane, lw) >>> ((cnt >= lw) ? lw - 1 : cnt)) & mask;
                    r = r | (64'(v) << (i*lw));
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input string req, input logic [4:0] o, input logic [63:0] a,
                         input logic [63:0] b, input bit isel, input logic [7:0] imm);
        logic [63:0] exp;
        exp = model(o, a, b, isel, imm);
        in_valid = 1'b1; op = o; opa = a; opb = b; imm_sel = isel; imm_cnt = imm;
        @(negedge clk);
        check({req, " R1 valid"}, {63'd0, out_valid}, 64'd1);
        check(req, out_data, exp);
    endtask

    function automatic logic [4:0] pick_op(input int unsigned k);
        logic [4:0] tbl [0:18] = '{5'h00, 5'h01, 5'h02, 5'h04, 5'h05, 5'h06, 5'h08,
                                   5'h09, 5'h0A, 5'h10, 5'h11, 5'h12, 5'h14, 5'h15,
                                   5'h16, 5'h18, 5'h19, 5'h03, 5'h1F};
        return tbl[k % 19];
    endfunction

    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'h00: return "R2";
            5'h01: return "R3";
            5'h02: return "R4";
            5'h04, 5'h05, 5'h06: return "R5";
            5'h08, 5'h09, 5'h0A: return "R6";
            5'h10, 5'h11, 5'h12, 5'h14, 5'h15, 5'h16: return "R7 R9";
            5'h18, 5'h19: return "R8 R9";
            default: return "R10";
        endcase
    endfunction

    initial begin
        logic [63:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset data", out_data, 64'd0);

        // R3: 300 -> 127, -144 -> -128
        issue("R3", 5'h01, {16'sd5, -16'sd200, -16'sd144, 16'sd300}, {16'h7FFF, 16'h8000, 16'd127, 16'hFF80}, 0, 0);
        issue("R2", 5'h00, {32'd70000, -32'sd70000}, {32'd32767, -32'sd32768}, 0, 0);
        issue("R4", 5'h02, {-16'sd5, 16'd256, 16'd255, 16'd0}, {16'h8000, 16'h7FFF, 16'd1, 16'd128}, 0, 0);
        issue("R5 zero extend", 5'h04, 64'h8877_6655_4433_2211, 64'd0, 0, 0);
        issue("R5", 5'h06, 64'hAAAA_AAAA_BBBB_BBBB, 64'hCCCC_CCCC_DDDD_DDDD, 0, 0);
        issue("R6", 5'h09, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 0, 0);
        issue("R6", 5'h08, 64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718, 0, 0);
        issue("R7 R9 per-lane", 5'h10, 64'hFFFF_FFFF_FFFF_FFFF, {16'd16, 16'd15, 16'd1, 16'd0}, 0, 0);
        issue("R7", 5'h12, 64'h1, 64'd0, 1, 8'd63);
        issue("R7 flush", 5'h12, 64'hFFFF_0000_1234_5678, 64'd0, 1, 8'd64);
        issue("R7 R9 per-lane", 5'h15, 64'h8000_0000_8000_0000, {32'd40, 32'd31}, 0, 0);
        issue("R8 fill", 5'h18, 64'h8000_7FFF_F000_0001, 64'd0, 1, 8'd16);
        issue("R8 R9 per-lane", 5'h19, 64'h8000_0000_7FFF_FFFF, {32'd4, 32'd32}, 0, 0);
        issue("R10", 5'h1F, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0);

        // R11: hold while idle
        held = out_data;
        in_valid = 1'b0; op = 5'h12; opa = 64'hDEAD; imm_sel = 1; imm_cnt = 8'd1;
        @(negedge clk);
        check("R11 hold", out_data, held);
        check("R1 idle valid", {63'd0, out_valid}, 64'd0);

        for (int n = 0; n < 600; n++) begin
            logic [4:0]  o;
            logic [63:0] a, b;
            bit          isel;
            o = pick_op($urandom);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            isel = $urandom % 2;
            if (!isel && o[4] && ($urandom % 2 == 1))
                b = {16'($urandom % 40), 16'($urandom % 40), 16'($urandom % 20), 16'($urandom % 20)};
            issue(req_of(o), o, a, b, isel, 8'($urandom % 72));
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule